// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the directory controller at the home node of a distributed shared-memory machine. The home memory is split into cache-line-sized blocks. For each block the controller keeps a coherence state and a presence vector with one bit per node. Requests arrive as messages from remote nodes and from the home node's own cache. The controller answers each one from home memory, or it first pulls the current copy back from whichever node holds the block modified. It also grants write ownership after it has invalidated every other copy.

Messages have a fixed layout: kind, source node, destination node, block index and a data word. They move over valid/ready ports. Requests use one input channel and the nodes' answers (acknowledges and returned data) use a second one, so an answer is never queued behind a new request. Every message the controller sends leaves through a single output channel, with the home node's number as source. The controller handles one transaction at a time and holds a busy flag on the block until that transaction ends. A probe port shows any block's directory entry and its memory word.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every block is uncached (state code 0) with an empty presence vector and is not busy. Memory word i holds 0x1000_0000 + i. No message is pending and a request can be accepted.
- R2: A read request (kind 1) for a block in state 0 or 1 is answered with one reply (kind 5). The reply goes to the requester, has the home node (node 0) as source, names the block and carries its memory word.
- R3: After such a read the block is Shared (state code 1). The requester's presence bit is set and the bits already set stay set.
- R4: A read of a Modified block (state code 2) first sends a fetch (kind 7) to the owner, and this holds when the owner is the home node itself. No reply leaves before the owner returns data (kind 4).
- R5: Data returned by an owner is written into home memory before the requester is served, and the reply carries that returned word.
- R6: After a read served through a fetch the block is Shared, and its presence vector holds exactly the old owner and the requester.
- R7: An ownership request (kind 6 grant is the answer to a request of kind 2) on a block that has sharers other than the requester sends an invalidate (kind 9) to each of those sharers, in ascending node order. The requester itself gets no invalidate. The grant is sent only after every invalidated node has acknowledged (kind 3).
- R8: When a block has no other holder, an ownership request is granted at once with the memory word. After any grant the block is Modified and its presence vector holds only the requester.
- R9: An ownership request on a block that another node holds Modified sends a flush (kind 8) to that owner. The returned word is written into memory and then carried by the grant.
- R10: Once a request is accepted, no other request is accepted until the transaction has finished, and the block reads as busy during the transaction.
- R11: Every outgoing message is a reply, grant, fetch, flush or invalidate (kinds 5 to 9). Fetch, flush and invalidate carry a zero data word.
- R12: While the output is valid and not accepted, it stays valid and its kind, destination, block and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Controller accepts a request |
| req_kind | input | 4 | Request kind: 1 read, 2 ownership |
| req_src | input | 2 | Requesting node |
| req_addr | input | 4 | Block index |
| rsp_valid | input | 1 | Node answer present |
| rsp_ready | output | 1 | Controller accepts an answer |
| rsp_kind | input | 4 | Answer kind: 3 acknowledge, 4 data |
| rsp_src | input | 2 | Answering node |
| rsp_addr | input | 4 | Block index of the answer |
| rsp_data | input | 32 | Returned line word |
| out_valid | output | 1 | Outgoing message present |
| out_ready | input | 1 | Fabric accepts the outgoing message |
| out_kind | output | 4 | Outgoing kind, 5 to 9 |
| out_src | output | 2 | Sender, always the home node |
| out_dst | output | 2 | Destination node |
| out_addr | output | 4 | Block index |
| out_data | output | 32 | Line word, zero for fetch, flush and invalidate |
| probe_addr | input | 4 | Block index to observe |
| probe_state | output | 2 | Observed state: 0 uncached, 1 shared, 2 modified |
| probe_sharers | output | 4 | Observed presence vector, bit n for node n |
| probe_busy | output | 1 | Observed block has a transaction open |
| probe_data | output | 32 | Observed memory word |

## Verification
The assertions check on every cycle that the output message is held under backpressure, that a second request is never accepted right after the first, that only legal outgoing kinds appear, and that the directory entry in view stays consistent: a Modified block has exactly one holder and an uncached block has none. Only the bench's scenarios can show the protocol ordering. Those scenarios cover fetch before reply, memory update before forwarding, invalidates in ascending order with the requester skipped, and the grant held back until the last acknowledge. They also show the exact presence vectors left behind after reads, fetch-reads and ownership changes, including the case where the home node's own cache is the owner.

// File: rtl/hdir_pkg.sv
package hdir_pkg;

    localparam int NODES  = 4;
    localparam int NODE_W = $clog2(NODES);
    localparam int LINES  = 16;
    localparam int LINE_W = $clog2(LINES);
    localparam int DATA_W = 32;
    localparam int KIND_W = 4;

    localparam logic [NODE_W-1:0] HOME_ID  = '0;
    localparam logic [DATA_W-1:0] MEM_BASE = 32'h1000_0000;

    typedef enum logic [KIND_W-1:0] {
        MK_NONE  = 4'd0,
        MK_READ  = 4'd1,
        MK_OWN   = 4'd2,
        MK_ACK   = 4'd3,
        MK_DATA  = 4'd4,
        MK_REPLY = 4'd5,
        MK_GRANT = 4'd6,
        MK_FETCH = 4'd7,
        MK_FLUSH = 4'd8,
        MK_INV   = 4'd9
    } mkind_e;

    typedef enum logic [1:0] {
        LS_UNCACHED = 2'd0,
        LS_SHARED   = 2'd1,
        LS_MODIFIED = 2'd2
    } lstate_e;

    typedef struct packed {
        mkind_e              kind;
        logic [NODE_W-1:0]   src;
        logic [NODE_W-1:0]   dst;
        logic [LINE_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } msg_t;

    typedef struct packed {
        lstate_e             st;
        logic [NODES-1:0]    pres;
        logic                busy;
    } dent_t;

    // Lowest-numbered node whose bit is set; zero for an empty mask.
    function automatic logic [NODE_W-1:0] first_node(input logic [NODES-1:0] m);
        logic [NODE_W-1:0] r;
        r = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (m[i]) r = NODE_W'(i);
        end
        return r;
    endfunction

    function automatic logic [NODES-1:0] node_bit(input logic [NODE_W-1:0] n);
        return NODES'(1) << n;
    endfunction

    function automatic msg_t make_msg(input mkind_e k, input logic [NODE_W-1:0] dst,
                                      input logic [LINE_W-1:0] addr,
                                      input logic [DATA_W-1:0] data);
        msg_t m;
        m.kind = k;
        m.src  = HOME_ID;
        m.dst  = dst;
        m.addr = addr;
        m.data = data;
        return m;
    endfunction

endpackage

// File: rtl/hdir_table.sv
module hdir_table
    import hdir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] rd_addr,
    output dent_t             rd_ent,
    input  logic [LINE_W-1:0] pb_addr,
    output dent_t             pb_ent,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_addr,
    input  dent_t             wr_ent
);

    dent_t ent_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                ent_q[i] <= '{st: LS_UNCACHED, pres: '0, busy: 1'b0};
            end
        end else if (wr_en) begin
            ent_q[wr_addr] <= wr_ent;
        end
    end

    assign rd_ent = ent_q[rd_addr];
    assign pb_ent = ent_q[pb_addr];

endmodule

// File: rtl/hdir_store.sv
module hdir_store
    import hdir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [LINE_W-1:0] pb_addr,
    output logic [DATA_W-1:0] pb_data,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] word_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                word_q[i] <= MEM_BASE + DATA_W'(i);
            end
        end else if (wr_en) begin
            word_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = word_q[rd_addr];
    assign pb_data = word_q[pb_addr];

endmodule

// File: rtl/hdir_engine.sv
module hdir_engine
    import hdir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  msg_t              req_msg,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  msg_t              rsp_msg,
    output logic              out_valid,
    input  logic              out_ready,
    output msg_t              out_msg,
    output logic [LINE_W-1:0] tbl_addr,
    input  dent_t             tbl_ent,
    output logic              tbl_we,
    output dent_t             tbl_wdata,
    output logic [LINE_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DECIDE,
        PH_INVAL,
        PH_WAIT_ACK,
        PH_WAIT_DATA,
        PH_FINISH
    } phase_e;

    phase_e           ph_q;
    msg_t             cur_q;
    msg_t             out_q;
    logic             out_v_q;
    dent_t            snap_q;
    logic [NODES-1:0] inv_q;
    logic [NODES-1:0] ack_q;

    logic             req_fire;
    logic             rsp_fire;
    logic             out_free;
    logic             is_read;
    logic [NODES-1:0] others;
    logic [NODES-1:0] req_bit;
    logic             data_hit;

    assign req_ready = (ph_q == PH_IDLE) && !out_v_q;
    assign rsp_ready = (ph_q == PH_INVAL) || (ph_q == PH_WAIT_ACK) || (ph_q == PH_WAIT_DATA);
    assign req_fire  = req_valid && req_ready;
    assign rsp_fire  = rsp_valid && rsp_ready;
    assign out_free  = !out_v_q;
    assign is_read   = (cur_q.kind == MK_READ);
    assign req_bit   = node_bit(cur_q.src);
    assign others    = tbl_ent.pres & ~req_bit;
    assign data_hit  = rsp_fire && (rsp_msg.kind == MK_DATA) && (rsp_msg.addr == cur_q.addr);

    assign tbl_addr  = cur_q.addr;
    assign mem_addr  = cur_q.addr;
    assign out_valid = out_v_q;
    assign out_msg   = out_q;

    // Directory and memory write ports.
    always_comb begin
        tbl_we    = 1'b0;
        tbl_wdata = snap_q;
        mem_we    = 1'b0;
        mem_wdata = rsp_msg.data;
        case (ph_q)
            PH_DECIDE: begin
                tbl_we         = 1'b1;
                tbl_wdata      = tbl_ent;
                tbl_wdata.busy = 1'b1;
            end
            PH_WAIT_DATA: begin
                mem_we = data_hit;
            end
            PH_FINISH: begin
                if (out_free) begin
                    tbl_we         = 1'b1;
                    tbl_wdata.busy = 1'b0;
                    if (is_read) begin
                        tbl_wdata.st   = LS_SHARED;
                        tbl_wdata.pres = snap_q.pres | req_bit;
                    end else begin
                        tbl_wdata.st   = LS_MODIFIED;
                        tbl_wdata.pres = req_bit;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            cur_q   <= '0;
            out_q   <= '0;
            out_v_q <= 1'b0;
            snap_q  <= '0;
            inv_q   <= '0;
            ack_q   <= '0;
        end else begin
            if (out_v_q && out_ready) out_v_q <= 1'b0;
            if (rsp_fire && rsp_msg.kind == MK_ACK) begin
                ack_q <= ack_q & ~node_bit(rsp_msg.src);
            end
            case (ph_q)
                PH_IDLE: begin
                    if (req_fire) begin
                        cur_q <= req_msg;
                        ph_q  <= PH_DECIDE;
                    end
                end
                PH_DECIDE: begin
                    snap_q <= tbl_ent;
                    if (tbl_ent.st == LS_MODIFIED) begin
                        out_q   <= make_msg(is_read ? MK_FETCH : MK_FLUSH,
                                            first_node(tbl_ent.pres), cur_q.addr, '0);
                        out_v_q <= 1'b1;
                        ph_q    <= PH_WAIT_DATA;
                    end else if (!is_read && others != '0) begin
                        inv_q <= others;
                        ack_q <= others;
                        ph_q  <= PH_INVAL;
                    end else begin
                        ph_q <= PH_FINISH;
                    end
                end
                PH_INVAL: begin
                    if (inv_q == '0) begin
                        ph_q <= PH_WAIT_ACK;
                    end else if (out_free) begin
                        out_q   <= make_msg(MK_INV, first_node(inv_q), cur_q.addr, '0);
                        out_v_q <= 1'b1;
                        inv_q   <= inv_q & ~node_bit(first_node(inv_q));
                    end
                end
                PH_WAIT_ACK: begin
                    if (ack_q == '0) ph_q <= PH_FINISH;
                end
                PH_WAIT_DATA: begin
                    if (data_hit) ph_q <= PH_FINISH;
                end
                PH_FINISH: begin
                    if (out_free) begin
                        out_q   <= make_msg(is_read ? MK_REPLY : MK_GRANT,
                                            cur_q.src, cur_q.addr, mem_rdata);
                        out_v_q <= 1'b1;
                        ph_q    <= PH_IDLE;
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
    import hdir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [KIND_W-1:0] req_kind,
    input  logic [NODE_W-1:0] req_src,
    input  logic [LINE_W-1:0] req_addr,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [KIND_W-1:0] rsp_kind,
    input  logic [NODE_W-1:0] rsp_src,
    input  logic [LINE_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [KIND_W-1:0] out_kind,
    output logic [NODE_W-1:0] out_src,
    output logic [NODE_W-1:0] out_dst,
    output logic [LINE_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    input  logic [LINE_W-1:0] probe_addr,
    output logic [1:0]        probe_state,
    output logic [NODES-1:0]  probe_sharers,
    output logic              probe_busy,
    output logic [DATA_W-1:0] probe_data
);

    msg_t              req_msg;
    msg_t              rsp_msg;
    msg_t              out_msg;
    logic [LINE_W-1:0] tbl_addr;
    dent_t             tbl_ent;
    logic              tbl_we;
    dent_t             tbl_wdata;
    dent_t             pb_ent;
    logic [LINE_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;

    assign req_msg = '{kind: mkind_e'(req_kind), src: req_src, dst: HOME_ID,
                       addr: req_addr, data: '0};
    assign rsp_msg = '{kind: mkind_e'(rsp_kind), src: rsp_src, dst: HOME_ID,
                       addr: rsp_addr, data: rsp_data};

    hdir_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_msg   (req_msg),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_msg   (rsp_msg),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_msg   (out_msg),
        .tbl_addr  (tbl_addr),
        .tbl_ent   (tbl_ent),
        .tbl_we    (tbl_we),
        .tbl_wdata (tbl_wdata),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata)
    );

    hdir_table u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (tbl_addr),
        .rd_ent  (tbl_ent),
        .pb_addr (probe_addr),
        .pb_ent  (pb_ent),
        .wr_en   (tbl_we),
        .wr_addr (tbl_addr),
        .wr_ent  (tbl_wdata)
    );

    hdir_store u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (mem_addr),
        .rd_data (mem_rdata),
        .pb_addr (probe_addr),
        .pb_data (probe_data),
        .wr_en   (mem_we),
        .wr_addr (mem_addr),
        .wr_data (mem_wdata)
    );

    assign out_kind      = out_msg.kind;
    assign out_src       = out_msg.src;
    assign out_dst       = out_msg.dst;
    assign out_addr      = out_msg.addr;
    assign out_data      = out_msg.data;
    assign probe_state   = pb_ent.st;
    assign probe_sharers = pb_ent.pres;
    assign probe_busy    = pb_ent.busy;

endmodule

// File: rtl/home_dir_ctrl_chk.sv
module home_dir_ctrl_chk
    import hdir_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [KIND_W-1:0] out_kind,
    input logic [NODE_W-1:0] out_dst,
    input logic [LINE_W-1:0] out_addr,
    input logic [DATA_W-1:0] out_data,
    input logic [1:0]        probe_state,
    input logic [NODES-1:0]  probe_sharers
);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    p_uncached_empty_r3: assert property (@(posedge clk) disable iff (rst)
        (probe_state == 2'd0) |-> (probe_sharers == '0));

    p_shared_has_holder_r3: assert property (@(posedge clk) disable iff (rst)
        (probe_state == 2'd1) |-> (probe_sharers != '0));

    p_single_owner_r8: assert property (@(posedge clk) disable iff (rst)
        (probe_state == 2'd2) |-> ($countones(probe_sharers) == 1));

    p_one_in_flight_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_legal_kind_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_kind >= 4'd5 && out_kind <= 4'd9));

    p_hold_out_r12: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_dst)
                                       && $stable(out_addr) && $stable(out_data)));

endmodule

bind home_dir_ctrl home_dir_ctrl_chk u_chk (.*);

// File: tb/home_dir_ctrl_test.sv
module home_dir_ctrl_test;
    import hdir_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [KIND_W-1:0] req_kind = '0;
    logic [NODE_W-1:0] req_src = '0;
    logic [LINE_W-1:0] req_addr = '0;
    logic              rsp_valid = 1'b0;
    logic              rsp_ready;
    logic [KIND_W-1:0] rsp_kind = '0;
    logic [NODE_W-1:0] rsp_src = '0;
    logic [LINE_W-1:0] rsp_addr = '0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [KIND_W-1:0] out_kind;
    logic [NODE_W-1:0] out_src;
    logic [NODE_W-1:0] out_dst;
    logic [LINE_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;
    logic [LINE_W-1:0] probe_addr = '0;
    logic [1:0]        probe_state;
    logic [NODES-1:0]  probe_sharers;
    logic              probe_busy;
    logic [DATA_W-1:0] probe_data;

    home_dir_ctrl uut (.*);

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit bp_on = 1'b0;
    int rsp_delay = 0;
    bit done = 1'b0;

    // Expected outgoing messages and the requirement each one proves.
    msg_t  exp_q [$];
    string tag_q [$];
    // Answers the modelled nodes owe the controller.
    msg_t  ans_q [$];

    // Reference model of the directory, memory and node caches.
    int                mst   [LINES];
    logic [NODES-1:0]  mpres [LINES];
    logic [DATA_W-1:0] mmem  [LINES];
    logic [DATA_W-1:0] nval  [NODES];
    int                step = 0;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_out(input mkind_e k, input int dst, input int addr,
                              input logic [DATA_W-1:0] data, input string tag);
        exp_q.push_back(make_msg(k, NODE_W'(dst), LINE_W'(addr), data));
        tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Backpressure on the output channel.
    always @(posedge clk) begin
        #1;
        out_ready = bp_on ? ($urandom % 2 == 1) : 1'b1;
    end

    // Monitor: pops the scoreboard on every accepted output message.
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R11 unexpected message actual=%0h expected=none", out_kind);
            end else begin
                msg_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, "kind", 64'(out_kind), 64'(e.kind));
                check(t, "dst",  64'(out_dst),  64'(e.dst));
                check("R11", "src", 64'(out_src), 64'(HOME_ID));
                check(t, "addr", 64'(out_addr), 64'(e.addr));
                check(t, "data", 64'(out_data), 64'(e.data));
            end
            if (out_kind == MK_FETCH || out_kind == MK_FLUSH) begin
                ans_q.push_back('{kind: MK_DATA, src: out_dst, dst: HOME_ID,
                                  addr: out_addr, data: nval[out_dst]});
            end else if (out_kind == MK_INV) begin
                ans_q.push_back('{kind: MK_ACK, src: out_dst, dst: HOME_ID,
                                  addr: out_addr, data: '0});
            end
        end
    end

    // Responder: the remote nodes answering fetches, flushes and invalidates.
    initial begin
        forever begin
            @(negedge clk);
            if (ans_q.size() > 0) begin
                msg_t a;
                a = ans_q.pop_front();
                repeat (rsp_delay) @(negedge clk);
                rsp_valid = 1'b1;
                rsp_kind  = a.kind;
                rsp_src   = a.src;
                rsp_addr  = a.addr;
                rsp_data  = a.data;
                #1;
                while (!rsp_ready) begin
                    @(negedge clk);
                    #1;
                end
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    // Driver: computes the expected messages from the model, then issues one request.
    task automatic do_req(input mkind_e kind, input int src, input int addr, input string tag);
        int               own;
        logic [NODES-1:0] oth;
        own = 0;
        for (int n = NODES - 1; n >= 0; n--) if (mpres[addr][n]) own = n;
        if (kind == MK_READ) begin
            if (mst[addr] == 2) begin
                expect_out(MK_FETCH, own, addr, '0, "R4");
                mmem[addr] = nval[own];
                expect_out(MK_REPLY, src, addr, mmem[addr], "R5");
            end else begin
                expect_out(MK_REPLY, src, addr, mmem[addr], "R2");
            end
            mst[addr] = 1;
            mpres[addr] = mpres[addr] | (NODES'(1) << src);
        end else begin
            if (mst[addr] == 2) begin
                expect_out(MK_FLUSH, own, addr, '0, "R9");
                mmem[addr] = nval[own];
                expect_out(MK_GRANT, src, addr, mmem[addr], "R9");
            end else begin
                oth = mpres[addr] & ~(NODES'(1) << src);
                for (int n = 0; n < NODES; n++) begin
                    if (oth[n]) expect_out(MK_INV, n, addr, '0, "R7");
                end
                expect_out(MK_GRANT, src, addr, mmem[addr], oth != '0 ? "R7" : "R8");
            end
            mst[addr] = 2;
            mpres[addr] = NODES'(1) << src;
        end

        @(negedge clk);
        probe_addr = LINE_W'(addr);
        req_valid  = 1'b1;
        req_kind   = kind;
        req_src    = NODE_W'(src);
        req_addr   = LINE_W'(addr);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check("R10", "ready after accept", 64'(req_ready), 64'd0);
        @(negedge clk);
        check("R10", "busy mid-transaction", 64'(probe_busy), 64'd1);
        check("R10", "ready mid-transaction", 64'(req_ready), 64'd0);
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        #1;
        check(tag, "state", 64'(probe_state), 64'(mst[addr]));
        check(tag, "sharers", 64'(probe_sharers), 64'(mpres[addr]));
        check(tag, "busy cleared", 64'(probe_busy), 64'd0);
        check(tag, "memory", 64'(probe_data), 64'(mmem[addr]));
        if (kind == MK_OWN) begin
            step++;
            nval[src] = 32'hC000_0000 | (32'(step) << 8) | 32'(src);
        end
    endtask

    initial begin
        for (int i = 0; i < LINES; i++) begin
            mst[i]   = 0;
            mpres[i] = '0;
            mmem[i]  = MEM_BASE + DATA_W'(i);
        end
        for (int n = 0; n < NODES; n++) nval[n] = '0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "out_valid", 64'(out_valid), 64'd0);
        check("R1", "req_ready", 64'(req_ready), 64'd1);
        for (int i = 0; i < LINES; i++) begin
            probe_addr = LINE_W'(i);
            #1;
            check("R1", "state", 64'(probe_state), 64'd0);
            check("R1", "sharers", 64'(probe_sharers), 64'd0);
            check("R1", "memory", 64'(probe_data), 64'(MEM_BASE + DATA_W'(i)));
        end

        do_req(MK_READ, 1, 3, "R3");    // uncached read
        do_req(MK_READ, 2, 3, "R3");    // second sharer kept with first
        rsp_delay = 3;
        do_req(MK_OWN, 3, 3, "R7");     // invalidates nodes 1 and 2 in order
        rsp_delay = 0;
        do_req(MK_READ, 1, 3, "R6");    // fetch from remote owner 3
        do_req(MK_OWN, 0, 5, "R8");     // home cache takes an unshared block
        do_req(MK_READ, 2, 5, "R6");    // fetch from the home node's own cache
        rsp_delay = 2;
        do_req(MK_OWN, 2, 5, "R7");     // requester is a sharer and is skipped
        do_req(MK_OWN, 1, 5, "R9");     // flush from remote owner 2
        bp_on = 1'b1;
        do_req(MK_READ, 3, 5, "R12");   // fetch under output backpressure
        do_req(MK_READ, 0, 5, "R12");
        do_req(MK_OWN, 2, 5, "R12");    // invalidates 0, 1 and 3 under backpressure
        bp_on = 1'b0;
        rsp_delay = 0;
        do_req(MK_OWN, 1, 15, "R8");    // last block
        do_req(MK_READ, 3, 0, "R2");    // first block
        do_req(MK_READ, 1, 15, "R5");   // fetch from owner of the last block

        done = 1'b1;
        repeat (4) @(negedge clk);
        check("R11", "stray messages", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

endmodule